// File: doc/BRIEF.md
# Light Sensor Integration Cycle Controller

This block sequences the integration cycles of a light-to-digital sensor. Software reaches it through a small register port. A control register holds a power bit and a conversion-enable bit, and it reports two read-only flags: result-valid and interrupt. An 8-bit timing register sets how many fixed integration intervals one cycle lasts. An external pulse, `intervalTick`, marks the end of each interval. The block does not measure intervals itself.

The timing value is the two's complement of the wanted interval count, and zero selects manual mode. Integration waits for a settling time after power-up, counted in system clock cycles. Counted cycles then repeat back to back while the block stays enabled. Each cycle that completes sets the valid and interrupt flags. Software clears the interrupt with a write to a command address. Turning power off stops integration and clears both flags.

Top module: `light_integ_ctrl`

## Requirements
- R1: Address 0 reads as {2'b00, interrupt, valid, 2'b00, enable, power}, where power is bit 0, enable is bit 1, valid is bit 4 and interrupt is bit 5. A write to address 0 stores only bits 1:0. Address 1 reads back the 8-bit timing value. Address 2 reads 0.
- R2: After reset, both registers read 0x00, both flags are 0 and `integActive` is 0.
- R3: Integration starts only when power and enable are both 1 and `SETTLE_CYCLES` clock cycles have passed since power last went from 0 to 1. Each new power-up restarts this settling count.
- R4: With a nonzero timing value T, a counted cycle lasts 256-T interval ticks. The counter loads T and counts ticks until it wraps from 0xFF. Valid and interrupt become 1 at the clock edge that samples the final tick.
- R5: `integActive` is 1 from the edge at which a cycle starts until the cycle ends or is stopped.
- R6: While the block stays enabled, a counted cycle is followed at once by the next one. A timing value written during a cycle applies from the next cycle on.
- R7: Once set, the interrupt flag stays 1 until a write to address 2 clears it. The valid flag stays 1 while power stays on. If a cycle completes in the same cycle as a clear write, the flag is set.
- R8: A timing value of 0 selects manual mode. The cycle runs while enable stays 1, and clearing enable ends it with both flags set.
- R9: When power is cleared, integration stops without setting any flag, and both flags return to 0.
- R10: When enable is cleared during a counted cycle, the cycle is aborted and no flag is set.
- R11: Interval ticks have no effect while no cycle is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address: 0 control, 1 timing, 2 interrupt clear |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| intervalTick | input | 1 | One-cycle pulse at the end of each integration interval |
| irqOut | output | 1 | Interrupt flag |
| integActive | output | 1 | An integration cycle is in progress |

## Verification
The hardest case to reach from the ports is the boundary of a counted cycle. A new timing value, the last tick and a clear write can all meet near the wrap, where a one-cycle error in the load or the flag update does not show. The stimulus writes a new timing value partway through a running cycle. It then counts ticks across two back-to-back cycles and checks the flags on the exact tick of each wrap. Power is cycled after settling so that the restart of the settling count is seen at the ports. A reference model running alongside compares every output on every clock.

// File: rtl/light_integ_pkg.sv
package light_integ_pkg;
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_TIME = 1;
  localparam int ADDR_CLR  = 2;

  localparam int BIT_PWR   = 0;
  localparam int BIT_EN    = 1;
  localparam int BIT_VALID = 4;
  localparam int BIT_IRQ   = 5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COUNT  = 2'd1,
    ST_MANUAL = 2'd2
  } integState_t;

  typedef struct packed {
    logic loadCnt;
    logic incCnt;
    logic setDone;
  } integStrobe_t;
endpackage

// File: rtl/light_integ_datapath.sv
module light_integ_datapath
  import light_integ_pkg::*;
#(
  parameter int ADDR_W        = 2,
  parameter int SETTLE_CYCLES = 400000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  integStrobe_t      strobe,
  output logic              pwrOn,
  output logic              adcEnable,
  output logic              settled,
  output logic              timingZero,
  output logic              cntAtMax,
  output logic              irqFlag
);
  localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SET_W-1:0] SET_LIMIT = SET_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] timingReg;
  logic [CNT_W-1:0] intervalCnt;
  logic [SET_W-1:0] settleCnt;
  logic             validFlag;
  logic             clrHit;

  assign clrHit = wrEn && (addr == ADDR_W'(ADDR_CLR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrOn     <= 1'b0;
      adcEnable <= 1'b0;
      timingReg <= '0;
    end else if (wrEn) begin
      if (addr == ADDR_W'(ADDR_CTRL)) begin
        pwrOn     <= wrData[BIT_PWR];
        adcEnable <= wrData[BIT_EN];
      end else if (addr == ADDR_W'(ADDR_TIME)) begin
        timingReg <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 settleCnt <= '0;
    else if (!pwrOn)           settleCnt <= '0;
    else if (settleCnt != SET_LIMIT) settleCnt <= settleCnt + 1'b1;
  end
  assign settled = (settleCnt == SET_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               intervalCnt <= '0;
    else if (strobe.loadCnt) intervalCnt <= timingReg;
    else if (strobe.incCnt)  intervalCnt <= intervalCnt + 1'b1;
  end
  assign cntAtMax   = (intervalCnt == CNT_MAX);
  assign timingZero = (timingReg == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validFlag <= 1'b0;
      irqFlag   <= 1'b0;
    end else if (!pwrOn) begin
      validFlag <= 1'b0;
      irqFlag   <= 1'b0;
    end else if (strobe.setDone) begin
      validFlag <= 1'b1;
      irqFlag   <= 1'b1;
    end else if (clrHit) begin
      irqFlag   <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(ADDR_CTRL)) begin
      rdData[BIT_PWR]   = pwrOn;
      rdData[BIT_EN]    = adcEnable;
      rdData[BIT_VALID] = validFlag;
      rdData[BIT_IRQ]   = irqFlag;
    end else if (addr == ADDR_W'(ADDR_TIME)) begin
      rdData = timingReg;
    end
  end

  AST_FLAG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(strobe.setDone)); // R4
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (validFlag && pwrOn) |=> validFlag); // R7
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && clrHit && !strobe.setDone) |=> !irqFlag); // R7
  AST_POWER_OFF_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !pwrOn |=> (!irqFlag && !validFlag)); // R9
endmodule

// File: rtl/light_integ_control.sv
module light_integ_control
  import light_integ_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         pwrOn,
  input  logic         adcEnable,
  input  logic         settled,
  input  logic         timingZero,
  input  logic         cntAtMax,
  output integStrobe_t strobe,
  output logic         active
);
  integState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (pwrOn && adcEnable && settled) begin
          if (timingZero) begin
            stateNext = ST_MANUAL;
          end else begin
            stateNext      = ST_COUNT;
            strobe.loadCnt = 1'b1;
          end
        end
      end
      ST_COUNT: begin
        if (!pwrOn || !adcEnable) begin
          stateNext = ST_IDLE;
        end else if (tick) begin
          if (cntAtMax) begin
            strobe.setDone = 1'b1;
            if (timingZero) stateNext = ST_MANUAL;
            else            strobe.loadCnt = 1'b1;
          end else begin
            strobe.incCnt = 1'b1;
          end
        end
      end
      ST_MANUAL: begin
        if (!pwrOn) begin
          stateNext = ST_IDLE;
        end else if (!adcEnable) begin
          strobe.setDone = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign active = (state != ST_IDLE);

  AST_NO_START_UNSETTLED: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !(pwrOn && adcEnable && settled)) |=> !active); // R3
  AST_POWER_OFF_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    !pwrOn |=> !active); // R9
  AST_ENABLE_OFF_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    !adcEnable |=> !active); // R10
  AST_IDLE_TICK_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !strobe.setDone); // R11
endmodule

// File: rtl/light_integ_ctrl.sv
module light_integ_ctrl
  import light_integ_pkg::*;
#(
  parameter int ADDR_W        = 2,
  parameter int SETTLE_CYCLES = 400000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              intervalTick,
  output logic              irqOut,
  output logic              integActive
);
  integStrobe_t strobe;
  logic pwrOn, adcEnable, settled, timingZero, cntAtMax;

  light_integ_datapath #(
    .ADDR_W(ADDR_W),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) i_datapath (
    .clk(clk), .rstN(rstN),
    .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData), .rdData(regRdData),
    .strobe(strobe),
    .pwrOn(pwrOn), .adcEnable(adcEnable), .settled(settled),
    .timingZero(timingZero), .cntAtMax(cntAtMax), .irqFlag(irqOut)
  );

  light_integ_control i_control (
    .clk(clk), .rstN(rstN), .tick(intervalTick),
    .pwrOn(pwrOn), .adcEnable(adcEnable), .settled(settled),
    .timingZero(timingZero), .cntAtMax(cntAtMax),
    .strobe(strobe), .active(integActive)
  );
endmodule

// File: tb/test_light_integ_ctrl.sv
`timescale 1ns/1ps
module test_light_integ_ctrl;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic intervalTick = 1'b0;
  logic irqOut, integActive;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  light_integ_ctrl #(.ADDR_W(2), .SETTLE_CYCLES(SETTLE)) i_light_integ_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .intervalTick(intervalTick),
    .irqOut(irqOut), .integActive(integActive)
  );

  // behavioural reference: mode 0 idle, 1 counted, 2 manual
  int mPwr, mEn, mTim, mSettle, mMode, mCnt, mValid, mIrq;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPwr = 0; mEn = 0; mTim = 0; mSettle = 0; mMode = 0; mCnt = 0;
      mValid = 0; mIrq = 0;
    end else begin
      int nMode, nCnt, nSettle;
      bit done;
      done = 0; nMode = mMode; nCnt = mCnt;
      if (mMode == 0) begin
        if (mPwr == 1 && mEn == 1 && mSettle == SETTLE) begin
          if (mTim == 0) nMode = 2;
          else begin nMode = 1; nCnt = mTim; end
        end
      end else if (mMode == 1) begin
        if (mPwr == 0 || mEn == 0) nMode = 0;
        else if (intervalTick) begin
          if (mCnt == 255) begin
            done = 1;
            if (mTim == 0) nMode = 2; else nCnt = mTim;
          end else nCnt = mCnt + 1;
        end
      end else begin
        if (mPwr == 0) nMode = 0;
        else if (mEn == 0) begin done = 1; nMode = 0; end
      end
      nSettle = (mPwr == 0) ? 0 : (mSettle < SETTLE ? mSettle + 1 : mSettle);
      if (mPwr == 0) begin mValid = 0; mIrq = 0; end
      else if (done) begin mValid = 1; mIrq = 1; end
      else if (regWrEn && regAddr == 2'd2) mIrq = 0;
      if (regWrEn && regAddr == 2'd0) begin mPwr = regWrData[0]; mEn = regWrData[1]; end
      if (regWrEn && regAddr == 2'd1) mTim = regWrData;
      mMode = nMode; mCnt = nCnt; mSettle = nSettle;
    end
  end

  function automatic int expRead(input logic [1:0] a);
    if (a == 2'd0) return (mIrq << 5) | (mValid << 4) | (mEn << 1) | mPwr;
    if (a == 2'd1) return mTim;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check("R7 irqOut", irqOut, mIrq);
      check("R5 integActive", integActive, (mMode != 0) ? 1 : 0);
      check("R1 regRdData", regRdData, expRead(regAddr));
    end
    if (cycles > 100000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regAddr = 2'd0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    intervalTick = 1'b1;
    @(posedge clk); #1;
    intervalTick = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input int exp);
    regAddr = a; #1;
    check(req, regRdData, exp);
    regAddr = 2'd0;
  endtask

  initial begin
    idle(0);
    #12 rstN = 1'b1;
    idle(2);
    // R2 reset state
    rd("R2 ctrl reset", 2'd0, 8'h00);
    rd("R2 timing reset", 2'd1, 8'h00);
    check("R2 active reset", integActive, 0);

    // R3: enable without power does nothing
    wr(2'd0, 8'h02);
    idle(SETTLE + 4);
    check("R3 no power", integActive, 0);

    // R1: only the low bits stick; R3: settling gate
    wr(2'd0, 8'hFF);
    rd("R1 ctrl writable bits", 2'd0, 8'h03);
    idle(SETTLE - 4);
    check("R3 before settle", integActive, 0);
    idle(6);
    check("R3 after settle manual", integActive, 1);

    // R8 manual mode ends on enable clear
    wr(2'd0, 8'h01);
    idle(1);
    check("R8 manual done irq", irqOut, 1);
    rd("R8 manual flags", 2'd0, 8'h31);

    // R7 clear keeps valid
    wr(2'd2, 8'h00);
    rd("R7 valid kept", 2'd0, 8'h11);
    rd("R1 clear addr reads zero", 2'd2, 8'h00);

    // R4 two intervals
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h03);
    idle(1);
    tick();
    check("R4 one of two ticks", irqOut, 0);
    tick();
    check("R4 after two ticks", irqOut, 1);
    check("R6 next cycle running", integActive, 1);

    // R6 new timing applies from the next cycle
    wr(2'd2, 8'h00);
    tick();
    wr(2'd1, 8'hFF);
    check("R6 old timing holds", irqOut, 0);
    tick();
    check("R6 old cycle ended", irqOut, 1);
    wr(2'd2, 8'h00);
    tick();
    check("R6 new single-tick cycle", irqOut, 1);

    // R4 maximum length
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h00);
    tick();
    wr(2'd2, 8'h00);
    for (int i = 0; i < 254; i++) tick();
    check("R4 254 of 255", irqOut, 0);
    tick();
    check("R4 255 ticks", irqOut, 1);

    // R10 abort
    wr(2'd2, 8'h00);
    tick();
    wr(2'd0, 8'h01);
    idle(1);
    check("R10 aborted", integActive, 0);
    // R11 ticks while idle
    for (int i = 0; i < 300; i++) tick();
    check("R11 idle ticks", irqOut, 0);

    // R9 power off clears flags, R3 settle restarts
    wr(2'd0, 8'h03);
    idle(2);
    check("R9 still running", integActive, 1);
    wr(2'd0, 8'h00);
    idle(1);
    check("R9 stopped", integActive, 0);
    rd("R9 flags cleared", 2'd0, 8'h00);
    wr(2'd0, 8'h03);
    idle(SETTLE - 4);
    check("R3 settle restarted", integActive, 0);
    idle(6);
    check("R3 restarted then active", integActive, 1);

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule